// File: doc/BRIEF.md
# Character-Cell Video Dot Generator

This block turns character codes into the serial dot stream of a text display. It runs on the dot clock. A cell counter divides that clock into character cells of six dot positions. Once per cell it pulses an active-low strobe that tells video RAM a character is being taken. At the end of that strobe cycle the block captures the code presented on `char_code` into its character latch.

In the following cell the latched code and the current 3-bit scan row address a built-in character generator. Each glyph is five dots wide and seven rows high. The five dots, plus a blank sixth dot that spaces neighbouring characters, are parallel-loaded into a shift register. The register then shifts out one dot per cell position, leftmost dot first.

Each load is gated in three ways:
- A window input marks whether the beam is inside the active picture or in a border. Outside the picture the load is blank.
- A CPU access flag, sampled at the fetch, marks that character as unreliable, so it is shown blank.
- A mode input selects a 64-column line or a 32-column line. In the 32-column line every dot, and so every cell, lasts twice as long.

Top module: `dotgen_text`

## Requirements
- R1: With `wide_mode` low, `latch_n` is low for exactly one clock in every 6 clocks.
- R2: With `wide_mode` high, `latch_n` is low for one clock in every 12 clocks, and every dot of a cell is held on `dot_out` for 2 consecutive clocks.
- R3: The code on `char_code` at a clock edge where `latch_n` is low is shown in the cell that starts one full cell after that edge. The cell that starts at that edge shows the previously latched code.
- R4: For a code whose bits [6:5] are not 00 and a scan row from 0 to 6, the cell shows the pattern `code[4:0]` rotated left by (row mod 5) bit places. The dots are sent in the order bit 4, 3, 2, 1, 0. A code with bits [6:5] equal to 00 shows no dots.
- R5: The sixth dot position of every cell is dark.
- R6: Scan row 7 shows a fully dark cell for every code.
- R7: If `in_window` is low at the clock edge where `latch_n` is low, the cell that starts at that edge is fully dark.
- R8: If `cpu_access` is high at a clock edge where `latch_n` is low, the character captured at that edge is shown as a fully dark cell. The cells before and after it are unaffected.
- R9: During reset `dot_out` is low and `latch_n` is high. After reset is released, the first low on `latch_n` appears after the fifth rising edge of the clock in 64-column mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 32-column double-width dots, 0 selects 64 columns |
| char_code | input | 7 | Character code read from video RAM |
| scan_row | input | 3 | Row of the glyph being scanned, 0 to 7 |
| in_window | input | 1 | High while the beam is inside the active picture |
| cpu_access | input | 1 | High while the CPU holds the video RAM |
| latch_n | output | 1 | Low during the last clock of each cell; the code is captured at its end |
| dot_out | output | 1 | Serial dot, 1 is lit |

## Verification
The assertions check the following on every clock:
- the strobe period in both modes while the mode is steady;
- that the spacing dot is dark;
- that a cell loaded at row 7 starts dark;
- that a cell loaded outside the window starts dark.

Only the bench scenarios can show the glyph content for given codes and rows, the one-cell delay between capture and display, and the effect of a CPU access on exactly one character. Each of these depends on which code was presented several cells earlier.

// File: rtl/dotgen_pkg.sv
package dotgen_pkg;
  localparam int unsigned CODE_W     = 7;
  localparam int unsigned ROW_W      = 3;
  localparam int unsigned GLYPH_W    = 5;
  localparam int unsigned GLYPH_ROWS = 7;
  localparam int unsigned CELL_W     = 6;
  localparam int unsigned CNT_W      = $clog2(CELL_W);
endpackage

// File: rtl/dotgen_timing.sv
module dotgen_timing #(
  parameter int unsigned CELL   = 6,
  localparam int unsigned CNT_W = $clog2(CELL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  output logic adv_en,
  output logic cell_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;

  // In wide mode the dot position advances on every second clock.
  always_comb begin
    half_d   = wide ? ~half_q : 1'b0;
    adv_en   = ~wide | half_q;
    cell_end = adv_en && (cnt_q == CNT_W'(CELL - 1));
    cnt_d    = cnt_q;
    if (adv_en) cnt_d = cell_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end
endmodule

// File: rtl/dotgen_glyph_gen.sv
module dotgen_glyph_gen #(
  parameter int unsigned CODE_W     = 7,
  parameter int unsigned ROW_W      = 3,
  parameter int unsigned GLYPH_W    = 5,
  parameter int unsigned GLYPH_ROWS = 7
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [ROW_W-1:0]   row,
  output logic [GLYPH_W-1:0] dots
);
  int unsigned rot;
  logic        printable;

  // Computed font: the low code bits form the row pattern, which is
  // rotated by the scan row.
  always_comb begin
    rot       = int'(row) % GLYPH_W;
    printable = (code[CODE_W-1 -: 2] != 2'b00) && (int'(row) < GLYPH_ROWS);
    dots      = '0;
    if (printable) begin
      for (int i = 0; i < GLYPH_W; i++) begin
        dots[(i + rot) % GLYPH_W] = code[i];
      end
    end
  end
endmodule

// File: rtl/dotgen_shifter.sv
module dotgen_shifter #(
  parameter int unsigned GLYPH_W = 5,
  parameter int unsigned CELL    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [GLYPH_W-1:0] dots,
  output logic               dot_out
);
  localparam int unsigned PAD = CELL - GLYPH_W;

  logic [CELL-1:0] sh_q, sh_d;

  // The padding positions after the glyph form the blank spacing dot.
  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = {dots, {PAD{1'b0}}};
    else if (shift) sh_d = {sh_q[CELL-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dot_out = sh_q[CELL-1];
endmodule

// File: rtl/dotgen_text.sv
module dotgen_text
  import dotgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [CODE_W-1:0] char_code,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic              in_window,
  input  logic              cpu_access,
  output logic              latch_n,
  output logic              dot_out
);
  logic               adv_en, cell_end;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               hold_q, hold_d;
  logic [GLYPH_W-1:0] glyph, load_dots;

  dotgen_timing #(.CELL(CELL_W)) u_timing (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (wide_mode),
    .adv_en  (adv_en),
    .cell_end(cell_end)
  );

  dotgen_glyph_gen #(
    .CODE_W(CODE_W), .ROW_W(ROW_W), .GLYPH_W(GLYPH_W), .GLYPH_ROWS(GLYPH_ROWS)
  ) u_glyph (
    .code(code_q),
    .row (scan_row),
    .dots(glyph)
  );

  // The character latch and the CPU hold-off flag are both enabled at the
  // end of a cell.
  always_comb begin
    code_d    = cell_end ? char_code  : code_q;
    hold_d    = cell_end ? cpu_access : hold_q;
    load_dots = (in_window && !hold_q) ? glyph : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      hold_q <= 1'b1;
    end else begin
      code_q <= code_d;
      hold_q <= hold_d;
    end
  end

  dotgen_shifter #(.GLYPH_W(GLYPH_W), .CELL(CELL_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cell_end),
    .shift  (adv_en),
    .dots   (load_dots),
    .dot_out(dot_out)
  );

  assign latch_n = ~cell_end;
endmodule

// File: rtl/dotgen_text_checker.sv
module dotgen_text_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wide_mode,
  input logic [2:0] scan_row,
  input logic       in_window,
  input logic       latch_n,
  input logic       dot_out
);
  logic [4:0] gap_q;
  logic       seen_q, mchg_q, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      mchg_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      mode_q <= wide_mode;
      if (!latch_n) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
        mchg_q <= (wide_mode != mode_q);
      end else begin
        gap_q <= gap_q + 1'b1;
        if (wide_mode != mode_q) mchg_q <= 1'b1;
      end
    end
  end

  a_r1_narrow_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && seen_q && !mchg_q && !wide_mode && !mode_q) |-> (gap_q == 5'd5));

  a_r2_wide_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && seen_q && !mchg_q && wide_mode && mode_q) |-> (gap_q == 5'd11));

  a_r5_gap_dot_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |-> !dot_out);

  a_r6_row7_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && scan_row == 3'd7) |=> !dot_out);

  a_r7_border_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && !in_window) |=> !dot_out);

  a_r9_dark_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dot_out && latch_n));
endmodule

bind dotgen_text dotgen_text_checker u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wide_mode(wide_mode),
  .scan_row (scan_row),
  .in_window(in_window),
  .latch_n  (latch_n),
  .dot_out  (dot_out)
);

// File: tb/dotgen_text_bench.sv
module dotgen_text_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wide_mode;
  logic [6:0] char_code;
  logic [2:0] scan_row;
  logic       in_window;
  logic       cpu_access;
  logic       latch_n;
  logic       dot_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dotgen_text u_dotgen_text (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .char_code(char_code),
    .scan_row(scan_row), .in_window(in_window), .cpu_access(cpu_access),
    .latch_n(latch_n), .dot_out(dot_out)
  );

  function automatic logic [4:0] exp_glyph(logic [6:0] c, int row);
    logic [4:0] x;
    if (row >= 7 || c[6:5] == 2'b00) return 5'b0;
    x = c[4:0];
    repeat (row % 5) x = {x[3:0], x[4]};
    return x;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_latch();
    do @(negedge clk); while (latch_n !== 1'b0);
  endtask

  // Called right after a negedge with latch_n low; checks the following cell.
  task automatic capture_cell(string req, logic [4:0] exp, int hold);
    for (int d = 0; d < 6; d++) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(req, int'(dot_out), (d < 5) ? int'(exp[4-d]) : 0);
      end
    end
  endtask

  task automatic measure_gap(string req, int exp);
    int n;
    wait_latch();
    n = 0;
    do begin @(negedge clk); n++; end while (latch_n !== 1'b0);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0; wide_mode = 1'b0; char_code = 7'h41; scan_row = 3'd0;
    in_window = 1'b1; cpu_access = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset dot", int'(dot_out), 0);
    check("R9 reset latch", int'(latch_n), 1);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (latch_n !== 1'b0 && n < 20);
    check("R9 first strobe", n, 5);
  endtask

  task automatic t_narrow_period();
    measure_gap("R1 period", 6);
    measure_gap("R1 period again", 6);
  endtask

  task automatic t_glyphs();
    logic [6:0] codes [4] = '{7'h53, 7'h2A, 7'h7F, 7'h61};
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 7; r += 3) begin
        wait_latch();
        char_code = codes[k]; scan_row = 3'(r);
        wait_latch();
        capture_cell("R4 R5 glyph", exp_glyph(codes[k], r), 1);
      end
    end
  endtask

  task automatic t_control_code();
    wait_latch(); char_code = 7'h1F; scan_row = 3'd1;
    wait_latch();
    capture_cell("R4 control code dark", 5'b0, 1);
  endtask

  task automatic t_row7();
    wait_latch(); char_code = 7'h7F; scan_row = 3'd7;
    wait_latch();
    capture_cell("R6 row7", 5'b0, 1);
    scan_row = 3'd0;
  endtask

  task automatic t_pipeline();
    wait_latch(); char_code = 7'h55; scan_row = 3'd0;
    wait_latch(); char_code = 7'h4E;
    capture_cell("R3 old code first", exp_glyph(7'h55, 0), 1);
    capture_cell("R3 new code next", exp_glyph(7'h4E, 0), 1);
  endtask

  task automatic t_window();
    wait_latch(); char_code = 7'h5B; scan_row = 3'd0;
    wait_latch(); in_window = 1'b0;
    capture_cell("R7 border dark", 5'b0, 1);
    in_window = 1'b1;
    capture_cell("R7 window back", exp_glyph(7'h5B, 0), 1);
  endtask

  task automatic t_cpu();
    wait_latch(); char_code = 7'h5B; scan_row = 3'd2;
    wait_latch(); cpu_access = 1'b1;
    capture_cell("R8 before access", exp_glyph(7'h5B, 2), 1);
    cpu_access = 1'b0;
    capture_cell("R8 held char dark", 5'b0, 1);
    capture_cell("R8 after access", exp_glyph(7'h5B, 2), 1);
  endtask

  task automatic t_wide();
    wait_latch(); wide_mode = 1'b1; char_code = 7'h66; scan_row = 3'd1;
    wait_latch(); wait_latch();
    measure_gap("R2 wide period", 12);
    capture_cell("R2 wide hold", exp_glyph(7'h66, 1), 2);
    wide_mode = 1'b0;
    wait_latch();
    measure_gap("R1 back to narrow", 6);
  endtask

  initial begin
    t_reset();
    t_narrow_period();
    t_glyphs();
    t_control_code();
    t_row7();
    t_pipeline();
    t_window();
    t_cpu();
    t_wide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule